// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block turns characters into asynchronous serial frames on a single transmit line. The line sits at 1 while idle. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period. The stop period lasts 1, 1.5 or 2 bit times. A separate baud generator supplies an oversampling `tick`, and one bit time is `TICKS_PER_BIT` ticks (16 by default).

Characters arrive through a valid/ready handshake. The block latches the character together with the whole frame configuration when it accepts it, so a change to the configuration while a frame is on the line does not affect that frame. When the break input is set at acceptance, the block sends a frame of the same length with every bit held at 0, and the line then returns to idle.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset and between frames, `tx_line` is 1, `tx_ready` is 1 and `tx_busy` is 0. Nothing happens while `tx_valid` stays low.
- R2: In the clock edge where `tx_valid` and `tx_ready` are both high, `tx_line` goes to 0 for the start bit. The data bits follow least significant bit first.
- R3: `cfg_char_len` selects the number of data bits: code 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are not sent.
- R4: When `cfg_par_en` is 0, no parity bit is sent. When it is 1, a parity bit follows the data. With `cfg_par_mode` 0 (even), the parity bit equals the count modulo 2. With mode 1 (odd), it is the inverse of that value. The count is the number of 1 data bits when `cfg_par_zeros` is 0, and the number of 0 data bits when it is 1.
- R5: `cfg_par_mode` 2 (mark) always sends a parity bit of 1. Mode 3 (space) always sends 0. The `cfg_par_zeros` setting makes no difference in either mode.
- R6: `cfg_stop` sets the stop period to 16 ticks (code 0), 24 ticks (code 1) or 32 ticks (codes 2 and 3). The line is 1 for the whole stop period.
- R7: When `cfg_break` is 1 at acceptance, every bit of the frame, stop period included, is 0. The frame lasts as long as a normal frame under the same configuration. After it, the line is 1 and `tx_ready` is 1.
- R8: All configuration inputs and the data are sampled only at acceptance. Changing them during a frame does not alter that frame.
- R9: `tx_ready` is 1 only when the block is idle, and `tx_busy` is its inverse. While busy, a high `tx_valid` is ignored. The next character is accepted no sooner than one clock after `tx_ready` returns to 1.
- R10: The start, data and parity bits each last exactly 16 ticks. The line changes only in a clock edge where `tick` is high, except at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling strobe, TICKS_PER_BIT per bit |
| cfg_char_len | input | 2 | Data bits: code n gives DATA_W-3+n bits |
| cfg_stop | input | 2 | Stop period: 0 = 1 bit, 1 = 1.5 bits, 2/3 = 2 bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_mode | input | 2 | 0 even, 1 odd, 2 mark, 3 space |
| cfg_par_zeros | input | 1 | Even/odd counts 0 bits instead of 1 bits |
| cfg_break | input | 1 | Send an all-zero frame |
| tx_data | input | DATA_W | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Idle, able to accept |
| tx_busy | output | 1 | Frame in progress |
| tx_line | output | 1 | Serial output, idles high |

## Verification
The bench targets the 1.5-bit stop period. A design that counted only whole bits there would end the frame 8 ticks early or late. It checks parity that counts zeros at odd and even character lengths, where forgetting the length term flips the bit. It checks break frames: a design that let the stop period go high, or that shortened the frame, would show a 1 or an early `tx_ready`. It also scrambles the configuration and data during a frame and holds `tx_valid` high across busy periods. A block that read its inputs live, or accepted a character while busy, would produce bits that differ from the model's frame captured at acceptance.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [1:0] {
    PAR_EVEN  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_MARK  = 2'd2,
    PAR_SPACE = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } tx_state_e;

  // Stop period length in ticks for a given code.
  function automatic int unsigned stop_ticks(input logic [1:0] code, input int unsigned tpb);
    case (code)
      2'd0:    return tpb;
      2'd1:    return tpb + tpb / 2;
      default: return 2 * tpb;
    endcase
  endfunction

endpackage

// File: rtl/uft_parity_gen.sv
module uft_parity_gen #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len_code,
  input  logic [1:0]        mode,
  input  logic              count_zeros,
  output logic              par_bit
);
  import uft_pkg::*;

  localparam int unsigned MIN_CHAR = DATA_W - 3;

  logic [DATA_W-1:0] mask;
  logic              ones_odd;
  logic              len_odd;
  logic              cnt_odd;

  // One mask bit per data position, set when inside the selected length.
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (g < (MIN_CHAR + 32'(len_code)));
  end

  always_comb begin
    int unsigned nbits;
    nbits    = MIN_CHAR + 32'(len_code);
    ones_odd = ^(data & mask);
    len_odd  = nbits[0];
    // Zero count parity = one count parity xor length parity.
    cnt_odd  = count_zeros ? (ones_odd ^ len_odd) : ones_odd;
    case (par_mode_e'(mode))
      PAR_EVEN:  par_bit = cnt_odd;
      PAR_ODD:   par_bit = ~cnt_odd;
      PAR_MARK:  par_bit = 1'b1;
      default:   par_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/uft_tick_timer.sv
module uft_tick_timer #(
  parameter int unsigned TICKS_PER_BIT = 16
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   clear,
  input  logic                                   tick,
  input  logic [$clog2(2*TICKS_PER_BIT+1)-1:0]   limit,
  output logic                                   done
);
  localparam int unsigned CW = $clog2(2 * TICKS_PER_BIT + 1);

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end = (cnt == limit - CW'(1));
  assign done   = tick && !clear && at_end;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick) begin
      if (at_end) cnt <= '0;
      else        cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/uft_frame_ctrl.sv
module uft_frame_ctrl #(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned DATA_W        = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 tx_valid,
  input  logic [DATA_W-1:0]                    tx_data,
  input  logic [1:0]                           len_code,
  input  logic [1:0]                           stop_code,
  input  logic                                 par_en,
  input  logic                                 par_bit_in,
  input  logic                                 brk,
  input  logic                                 bit_done,
  output logic                                 tx_ready,
  output logic                                 tx_busy,
  output logic                                 tx_line,
  output logic                                 tmr_clear,
  output logic [$clog2(2*TICKS_PER_BIT+1)-1:0] tmr_limit
);
  import uft_pkg::*;

  localparam int unsigned MIN_CHAR = DATA_W - 3;
  localparam int unsigned CNT_W    = $clog2(DATA_W);
  localparam int unsigned LIM_W    = $clog2(2 * TICKS_PER_BIT + 1);

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bits_left;
  logic [CNT_W-1:0]  len_m1_q;
  logic              par_en_q;
  logic              par_q;
  logic              brk_q;
  logic [LIM_W-1:0]  stop_lim_q;
  logic              accept;

  assign accept    = tx_ready && tx_valid;
  assign tmr_clear = (state == ST_IDLE);
  assign tmr_limit = (state == ST_STOP) ? stop_lim_q : LIM_W'(TICKS_PER_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      shreg      <= '0;
      bits_left  <= '0;
      len_m1_q   <= '0;
      par_en_q   <= 1'b0;
      par_q      <= 1'b0;
      brk_q      <= 1'b0;
      stop_lim_q <= LIM_W'(TICKS_PER_BIT);
      tx_line    <= 1'b1;
      tx_ready   <= 1'b1;
      tx_busy    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            shreg      <= tx_data;
            len_m1_q   <= CNT_W'(MIN_CHAR - 1) + CNT_W'(len_code);
            par_en_q   <= par_en;
            par_q      <= par_bit_in;
            brk_q      <= brk;
            stop_lim_q <= LIM_W'(stop_ticks(stop_code, TICKS_PER_BIT));
            tx_line    <= 1'b0;
            tx_ready   <= 1'b0;
            tx_busy    <= 1'b1;
            state      <= ST_START;
          end
        end
        ST_START: begin
          if (bit_done) begin
            tx_line   <= shreg[0] & ~brk_q;
            shreg     <= shreg >> 1;
            bits_left <= len_m1_q;
            state     <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (bit_done) begin
            if (bits_left != '0) begin
              tx_line   <= shreg[0] & ~brk_q;
              shreg     <= shreg >> 1;
              bits_left <= bits_left - CNT_W'(1);
            end else if (par_en_q) begin
              tx_line <= par_q & ~brk_q;
              state   <= ST_PARITY;
            end else begin
              tx_line <= ~brk_q;
              state   <= ST_STOP;
            end
          end
        end
        ST_PARITY: begin
          if (bit_done) begin
            tx_line <= ~brk_q;
            state   <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (bit_done) begin
            tx_line  <= 1'b1;
            tx_ready <= 1'b1;
            tx_busy  <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        cfg_char_len,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_par_en,
  input  logic [1:0]        cfg_par_mode,
  input  logic              cfg_par_zeros,
  input  logic              cfg_break,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_busy,
  output logic              tx_line
);
  localparam int unsigned LIM_W = $clog2(2 * TICKS_PER_BIT + 1);

  logic             par_bit;
  logic             bit_done;
  logic             tmr_clear;
  logic [LIM_W-1:0] tmr_limit;

  uft_parity_gen #(.DATA_W(DATA_W)) i_par (
    .data        (tx_data),
    .len_code    (cfg_char_len),
    .mode        (cfg_par_mode),
    .count_zeros (cfg_par_zeros),
    .par_bit     (par_bit)
  );

  uft_tick_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_tmr (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clear),
    .tick  (tick),
    .limit (tmr_limit),
    .done  (bit_done)
  );

  uft_frame_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_W(DATA_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .len_code   (cfg_char_len),
    .stop_code  (cfg_stop),
    .par_en     (cfg_par_en),
    .par_bit_in (par_bit),
    .brk        (cfg_break),
    .bit_done   (bit_done),
    .tx_ready   (tx_ready),
    .tx_busy    (tx_busy),
    .tx_line    (tx_line),
    .tmr_clear  (tmr_clear),
    .tmr_limit  (tmr_limit)
  );

endmodule

// File: rtl/uft_tx_checker.sv
module uft_tx_checker #(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned DATA_W        = 8
) (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic cfg_break,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_busy,
  input logic tx_line
);
  localparam int unsigned MAX_TICKS = TICKS_PER_BIT * (DATA_W + 4);

  logic        brk_flag;
  int unsigned frame_ticks;

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_flag    <= 1'b0;
      frame_ticks <= 0;
    end else begin
      if (tx_valid && tx_ready) brk_flag <= cfg_break;
      if (!tx_busy)     frame_ticks <= 0;
      else if (tick)    frame_ticks <= frame_ticks + 1;
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> tx_line);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (!tx_line && !tx_ready));

  assert_frame_bound_R6: assert property (@(posedge clk) disable iff (rst)
    frame_ticks <= MAX_TICKS);

  assert_break_low_R7: assert property (@(posedge clk) disable iff (rst)
    (brk_flag && tx_busy) |-> !tx_line);

  assert_busy_inverse_R9: assert property (@(posedge clk) disable iff (rst)
    tx_busy == !tx_ready);

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_busy && !tick) |=> $stable(tx_line));

endmodule

bind uart_frame_tx uft_tx_checker #(.TICKS_PER_BIT(TICKS_PER_BIT), .DATA_W(DATA_W)) i_uft_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .cfg_break (cfg_break),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_busy   (tx_busy),
  .tx_line   (tx_line)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] cfg_char_len = 2'd3;
  logic [1:0] cfg_stop = 2'd0;
  logic       cfg_par_en = 1'b0;
  logic [1:0] cfg_par_mode = 2'd0;
  logic       cfg_par_zeros = 1'b0;
  logic       cfg_break = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready, tx_busy, tx_line;

  always #10 clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst(rst), .tick(tick),
    .cfg_char_len(cfg_char_len), .cfg_stop(cfg_stop), .cfg_par_en(cfg_par_en),
    .cfg_par_mode(cfg_par_mode), .cfg_par_zeros(cfg_par_zeros), .cfg_break(cfg_break),
    .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_busy(tx_busy), .tx_line(tx_line)
  );

  int    n_vec = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  // Behavioural reference: list of (level, ticks) segments
  int q_val[$];
  int q_dur[$];
  bit m_line  = 1'b1;
  bit m_ready = 1'b1;
  int remain  = 0;

  function automatic void build(input logic [7:0] d, input logic [1:0] lc, input logic [1:0] sc,
                                input logic pe, input logic [1:0] pm, input logic pz, input logic brk);
    int len, ones, cnt, pb, sd;
    len = 5 + lc;
    ones = 0;
    q_val.delete(); q_dur.delete();
    q_val.push_back(0); q_dur.push_back(16);
    for (int i = 0; i < len; i++) begin
      q_val.push_back(brk ? 0 : d[i]); q_dur.push_back(16);
      ones += d[i];
    end
    if (pe) begin
      cnt = pz ? (len - ones) : ones;
      case (pm)
        2'd0: pb = cnt % 2;
        2'd1: pb = 1 - (cnt % 2);
        2'd2: pb = 1;
        default: pb = 0;
      endcase
      q_val.push_back(brk ? 0 : pb); q_dur.push_back(16);
    end
    sd = (sc == 2'd0) ? 16 : (sc == 2'd1) ? 24 : 32;
    q_val.push_back(brk ? 0 : 1); q_dur.push_back(sd);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ready = 1'b1; m_line = 1'b1;
      q_val.delete(); q_dur.delete();
    end else if (m_ready && tx_valid) begin
      build(tx_data, cfg_char_len, cfg_stop, cfg_par_en, cfg_par_mode, cfg_par_zeros, cfg_break);
      m_line = q_val[0][0]; remain = q_dur[0]; m_ready = 1'b0;
    end else if (!m_ready && tick) begin
      remain--;
      if (remain == 0) begin
        void'(q_val.pop_front()); void'(q_dur.pop_front());
        if (q_val.size() == 0) begin
          m_ready = 1'b1; m_line = 1'b1;
        end else begin
          m_line = q_val[0][0]; remain = q_dur[0];
        end
      end
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("tx_line",  tx_line,  m_line);
      chk("tx_ready", tx_ready, m_ready);
      chk("tx_busy",  tx_busy,  !m_ready);
    end
  end

  // Tick generator: div 0 = pseudo-random
  int tick_div = 2;
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt++;
    if (tick_div == 0) tick = ($urandom % 3) == 0;
    else               tick = (tcnt % tick_div) == 0;
  end

  task automatic xmit(input logic [7:0] d, input logic [1:0] lc, input logic [1:0] sc,
                      input logic pe, input logic [1:0] pm, input logic pz, input logic brk,
                      input bit hold, input bit scr);
    @(negedge clk);
    while (!m_ready) @(negedge clk);
    tx_data = d; cfg_char_len = lc; cfg_stop = sc; cfg_par_en = pe;
    cfg_par_mode = pm; cfg_par_zeros = pz; cfg_break = brk; tx_valid = 1'b1;
    @(negedge clk);
    if (!hold) tx_valid = 1'b0;
    if (scr) begin
      tx_data = 8'($urandom); cfg_char_len = 2'($urandom); cfg_stop = 2'($urandom);
      cfg_par_en = 1'($urandom); cfg_par_mode = 2'($urandom);
      cfg_par_zeros = 1'($urandom); cfg_break = 1'($urandom);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    while (!m_ready) @(negedge clk);
    tx_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: idle after reset, valid low
    tag = "R1";
    @(negedge clk);
    chk("reset line",  tx_line,  1'b1);
    chk("reset ready", tx_ready, 1'b1);
    chk("reset busy",  tx_busy,  1'b0);
    repeat (40) @(negedge clk);

    // R2: start bit and LSB-first order, 8 bits
    tag = "R2";
    xmit(8'hA5, 2'd3, 2'd0, 0, 2'd0, 0, 0, 0, 0);
    xmit(8'h01, 2'd3, 2'd0, 0, 2'd0, 0, 0, 0, 0);
    drain();

    // R3: every character length, high bits must not appear
    tag = "R3";
    for (int lc = 0; lc < 4; lc++) begin
      xmit(8'hE5, 2'(lc), 2'd0, 0, 2'd0, 0, 0, 0, 0);
      xmit(8'h1A, 2'(lc), 2'd0, 0, 2'd0, 0, 0, 0, 0);
    end
    drain();

    // R4: even/odd, counting ones or zeros, odd and even lengths
    tag = "R4";
    for (int lc = 0; lc < 4; lc++)
      for (int pm = 0; pm < 2; pm++)
        for (int pz = 0; pz < 2; pz++)
          xmit(8'h6B + 8'(lc * 7), 2'(lc), 2'd0, 1, 2'(pm), 1'(pz), 0, 0, 0);
    drain();

    // R5: mark and space with both level settings
    tag = "R5";
    for (int pm = 2; pm < 4; pm++)
      for (int pz = 0; pz < 2; pz++)
        xmit(8'h3C, 2'd2, 2'd0, 1, 2'(pm), 1'(pz), 0, 0, 0);
    drain();

    // R6: stop lengths 1, 1.5, 2 and code 3
    tag = "R6";
    for (int sc = 0; sc < 4; sc++)
      xmit(8'hFF, 2'd3, 2'(sc), 1, 2'd0, 0, 0, 0, 0);
    drain();

    // R7: break frames of several shapes, then a normal frame
    tag = "R7";
    xmit(8'hFF, 2'd3, 2'd1, 1, 2'd2, 0, 1, 0, 0);
    xmit(8'hFF, 2'd0, 2'd2, 0, 2'd0, 0, 1, 0, 0);
    xmit(8'h55, 2'd3, 2'd0, 0, 2'd0, 0, 0, 0, 0);
    drain();

    // R8: inputs scrambled during each frame
    tag = "R8";
    for (int k = 0; k < 12; k++)
      xmit(8'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
           1'($urandom), 1'(k == 5), 0, 1);
    drain();

    // R9: valid held high across busy periods, data changing meanwhile
    tag = "R9";
    for (int k = 0; k < 6; k++)
      xmit(8'h90 + 8'(k), 2'd3, 2'(k % 3), 1'(k % 2), 2'd1, 0, 0, 1, 1);
    drain();

    // R10: tick every cycle, sparse ticks, irregular ticks
    tag = "R10";
    tick_div = 1;
    xmit(8'hC3, 2'd3, 2'd1, 1, 2'd0, 1, 0, 0, 0);
    xmit(8'h0F, 2'd1, 2'd0, 0, 2'd0, 0, 0, 0, 0);
    drain();
    tick_div = 5;
    xmit(8'h5A, 2'd2, 2'd2, 1, 2'd1, 0, 0, 0, 0);
    drain();
    tick_div = 0;
    for (int k = 0; k < 4; k++)
      xmit(8'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 2'($urandom),
           1'($urandom), 0, 0, 0);
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule